// File: doc/BRIEF.md
# Flow Control Update Scheduler

This block decides when the link layer has to send a credit update for each of the three flow-control credit classes: posted, non-posted and completion. Each class has its own request line to the transmit arbiter. A request is raised in two cases. The first is when the receive side frees credit of that class. The second is when the class has gone too long without an update while the link is in a powered state. The request stays high until the arbiter reports that the update has gone out.

The periodic deadline runs in clock cycles. It is derived from a clock frequency parameter and two interval parameters given in microseconds. There is a short interval and a long one, and a control bit selects the long one. A deadline never fires before its nominal interval. It fires exactly at the nominal interval, so it is always inside the allowed lateness margin. Classes that advertise infinite credit, and classes that are disabled, get no periodic updates.

Top module: `fc_update_sched`

## Requirements
- R1: A one-cycle `credit_free[i]` pulse on an enabled class sets `upd_req[i]` on the following clock edge, whatever the link state.
- R2: With `ext_sync` low when a class's interval starts, on an active link, for an enabled non-infinite class, `upd_req[i]` rises exactly BASE_US × CLK_MHZ cycles after the restarting edge and never earlier.
- R3: With `ext_sync` high when the interval starts, the same delay is EXT_US × CLK_MHZ cycles.
- R4: A class with `type_inf[i]` high raises no periodic request. A credit-freed pulse still raises one.
- R5: `link_state` encodes 0 = L0, 1 = L0s, 2 = L1 and 3 = link down. Only 0 and 1 count as active. In states 2 and 3 no periodic request is raised. On return to state 0 or 1 every interval restarts from zero.
- R6: `upd_req[i]` stays high until `upd_ack[i]` is seen. An acknowledge clears it on the next edge and restarts the interval. If `credit_free[i]` arrives in the same cycle, the request stays high.
- R7: A change of `ext_sync` while an interval is running does not alter that interval. It applies from the next restart.
- R8: A disabled class (`type_en[i]` low) drops its request on the next edge and raises none while disabled.
- R9: During reset all requests are low.
- R10: The classes are timed independently. Acknowledging one class does not move another class's deadline.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_state | input | 2 | Link power state: 0 L0, 1 L0s, 2 L1, 3 down |
| type_en | input | NTYPES | Per-class enable |
| type_inf | input | NTYPES | Per-class infinite-credit flag |
| ext_sync | input | 1 | Selects the long update interval |
| credit_free | input | NTYPES | Per-class pulse: credit has been freed |
| upd_ack | input | NTYPES | Per-class pulse: an update was sent |
| upd_req | output | NTYPES | Per-class update request |

## Verification
Each class's internal state is a cycle counter plus a latched interval choice. A fault in either one shows up as a request edge that comes too early or too late. If the latched interval choice is stale, the error is larger: the edge misses by the difference between the two intervals, 90 µs worth of cycles. The bench measures that edge to the cycle against the computed interval. It does this for every class in both active link states and with both interval settings. A fault in restart or gating leaves a request high, or low, where the arbiter expects the opposite. This is visible one cycle after the acknowledge, disable or credit pulse that should have acted.

// File: rtl/fc_sched_pkg.sv
package fc_sched_pkg;

  typedef enum logic [1:0] {
    LNK_L0   = 2'd0,
    LNK_L0S  = 2'd1,
    LNK_L1   = 2'd2,
    LNK_DOWN = 2'd3
  } link_pwr_e;

  localparam int unsigned FC_CLASSES = 3;

endpackage

// File: rtl/fc_link_gate.sv
module fc_link_gate
  import fc_sched_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] link_state,
  output logic       link_act,
  output logic       link_ret
);

  logic act_q;
  logic act_n;

  always_comb begin
    link_act = (link_state == LNK_L0) || (link_state == LNK_L0S);
    link_ret = link_act && !act_q;
    act_n    = link_act;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_q <= 1'b0;
    else        act_q <= act_n;
  end

endmodule

// File: rtl/fc_type_timer.sv
module fc_type_timer #(
  parameter int unsigned CNT_W    = 8,
  parameter int unsigned BASE_LIM = 30,
  parameter int unsigned EXT_LIM  = 120
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic inf,
  input  logic ext,
  input  logic cf,
  input  logic ack,
  input  logic active,
  input  logic link_ret,
  output logic req
);

  localparam logic [CNT_W-1:0] BASE_M1 = CNT_W'(BASE_LIM - 1);
  localparam logic [CNT_W-1:0] EXT_M1  = CNT_W'(EXT_LIM - 1);

  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             req_q, req_n;
  logic             mode_q, mode_n;
  logic             cnt_en;
  logic [CNT_W-1:0] lim_m1;

  always_comb begin
    lim_m1 = mode_q ? EXT_M1 : BASE_M1;
    mode_n = (cnt_q == '0) ? ext : mode_q;
    cnt_n  = cnt_q;
    req_n  = req_q;
    cnt_en = 1'b1;
    if (!en) begin
      cnt_n = '0;
      req_n = 1'b0;
    end else begin
      if (ack) req_n = 1'b0;
      if (ack || link_ret || inf) begin
        cnt_n = '0;
      end else if (active) begin
        if (cnt_q == lim_m1) req_n = 1'b1;
        else                 cnt_n = cnt_q + 1'b1;
      end else begin
        cnt_en = 1'b0;
      end
      if (cf) req_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      req_q  <= 1'b0;
      mode_q <= 1'b0;
    end else begin
      if (cnt_en) cnt_q <= cnt_n;
      req_q  <= req_n;
      mode_q <= mode_n;
    end
  end

  assign req = req_q;

endmodule

// File: rtl/fc_update_sched.sv
module fc_update_sched #(
  parameter int unsigned NTYPES  = fc_sched_pkg::FC_CLASSES,
  parameter int unsigned CLK_MHZ = 250,
  parameter int unsigned BASE_US = 30,
  parameter int unsigned EXT_US  = 120
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        link_state,
  input  logic [NTYPES-1:0] type_en,
  input  logic [NTYPES-1:0] type_inf,
  input  logic              ext_sync,
  input  logic [NTYPES-1:0] credit_free,
  input  logic [NTYPES-1:0] upd_ack,
  output logic [NTYPES-1:0] upd_req
);

  localparam int unsigned BASE_CYC = BASE_US * CLK_MHZ;
  localparam int unsigned EXT_CYC  = EXT_US * CLK_MHZ;
  localparam int unsigned CNT_W    = $clog2(EXT_CYC + 1);

  logic link_act;
  logic link_ret;

  fc_link_gate u_gate (
    .clk        (clk),
    .rst_n      (rst_n),
    .link_state (link_state),
    .link_act   (link_act),
    .link_ret   (link_ret)
  );

  for (genvar g = 0; g < NTYPES; g++) begin : g_cls
    fc_type_timer #(
      .CNT_W    (CNT_W),
      .BASE_LIM (BASE_CYC),
      .EXT_LIM  (EXT_CYC)
    ) u_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (type_en[g]),
      .inf      (type_inf[g]),
      .ext      (ext_sync),
      .cf       (credit_free[g]),
      .ack      (upd_ack[g]),
      .active   (link_act),
      .link_ret (link_ret),
      .req      (upd_req[g])
    );
  end

endmodule

// File: rtl/fc_update_sched_chk.sv
module fc_update_sched_chk #(
  parameter int unsigned NTYPES = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              link_act,
  input logic [NTYPES-1:0] type_en,
  input logic [NTYPES-1:0] type_inf,
  input logic [NTYPES-1:0] credit_free,
  input logic [NTYPES-1:0] upd_ack,
  input logic [NTYPES-1:0] upd_req
);

  for (genvar g = 0; g < NTYPES; g++) begin : g_chk
    // R1
    cf_sets_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (credit_free[g] && type_en[g]) |=> upd_req[g]);
    // R6
    req_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_req[g] && type_en[g] && !upd_ack[g]) |=> upd_req[g]);
    // R6
    ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_ack[g] && !credit_free[g]) |=> !upd_req[g]);
    // R8
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !type_en[g] |=> !upd_req[g]);
    // R4
    periodic_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(upd_req[g]) && !$past(credit_free[g])) |-> $past(link_act && !type_inf[g]));
  end

endmodule

bind fc_update_sched fc_update_sched_chk #(.NTYPES(NTYPES)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .link_act    (link_act),
  .type_en     (type_en),
  .type_inf    (type_inf),
  .credit_free (credit_free),
  .upd_ack     (upd_ack),
  .upd_req     (upd_req)
);

// File: tb/fc_update_sched_tb.sv
module fc_update_sched_tb;

  localparam int unsigned NT   = 3;
  localparam int unsigned MHZ  = 1;
  localparam int unsigned BUS  = 30;
  localparam int unsigned EUS  = 120;
  localparam int          BLIM = BUS * MHZ;
  localparam int          ELIM = EUS * MHZ;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [1:0]    link_state;
  logic [NT-1:0] type_en, type_inf, credit_free, upd_ack, upd_req;
  logic          ext_sync;

  int n_chk  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  fc_update_sched #(.NTYPES(NT), .CLK_MHZ(MHZ), .BASE_US(BUS), .EXT_US(EUS)) u_dut (
    .clk(clk), .rst_n(rst_n), .link_state(link_state), .type_en(type_en),
    .type_inf(type_inf), .ext_sync(ext_sync), .credit_free(credit_free),
    .upd_ack(upd_ack), .upd_req(upd_req)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_ack(input logic [NT-1:0] m);
    upd_ack = m; cyc(1); upd_ack = '0;
  endtask

  task automatic pulse_cf(input logic [NT-1:0] m);
    credit_free = m; cyc(1); credit_free = '0;
  endtask

  task automatic measure(input int i, output int c);
    pulse_ack(NT'(1) << i);
    c = 0;
    while (!upd_req[i] && c < 400) begin cyc(1); c++; end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    finish_run();
  end

  initial begin
    int c;
    rst_n = 1'b0; link_state = 2'd0; type_en = '0; type_inf = '0;
    ext_sync = 1'b0; credit_free = '0; upd_ack = '0;
    cyc(3);
    chk("R9 reset requests", int'(upd_req), 0);
    rst_n = 1'b1; type_en = '1;
    cyc(2);

    // R2 / R3 sweep: every class, both active states, both intervals
    for (int e = 0; e < 2; e++) begin
      for (int ls = 0; ls < 2; ls++) begin
        for (int i = 0; i < NT; i++) begin
          ext_sync = e[0]; link_state = ls[1:0];
          measure(i, c);
          chk(e ? "R3 long interval" : "R2 short interval", c, e ? ELIM : BLIM);
        end
      end
    end

    // R7: mid-interval change ignored until next restart
    ext_sync = 1'b0; link_state = 2'd0;
    pulse_ack(3'b001); c = 0;
    while (!upd_req[0] && c < 400) begin
      if (c == 5) ext_sync = 1'b1;
      cyc(1); c++;
    end
    chk("R7 running interval kept", c, BLIM);
    measure(0, c);
    chk("R7 applied at restart", c, ELIM);
    ext_sync = 1'b0;

    // R4: infinite class
    type_inf = 3'b010;
    pulse_ack(3'b010); cyc(200);
    chk("R4 infinite no periodic", int'(upd_req[1]), 0);
    pulse_cf(3'b010);
    chk("R4 infinite credit pulse", int'(upd_req[1]), 1);
    type_inf = '0;

    // R5: inactive states, then restart from zero
    for (int ls = 2; ls < 4; ls++) begin
      link_state = ls[1:0];
      pulse_ack('1); cyc(200);
      chk("R5 no periodic when inactive", int'(upd_req), 0);
      link_state = 2'd0; cyc(1); c = 0;
      while (!upd_req[0] && c < 400) begin cyc(1); c++; end
      chk("R5 restart on return", c, BLIM);
      chk("R5 all classes restart", int'(upd_req), 7);
    end
    pulse_ack('1); cyc(20);
    link_state = 2'd2; cyc(50);
    link_state = 2'd1; cyc(1); c = 0;
    while (!upd_req[2] && c < 400) begin cyc(1); c++; end
    chk("R5 partial count discarded", c, BLIM);

    // R1: credit pulse while link down
    link_state = 2'd3; pulse_ack('1);
    pulse_cf(3'b100);
    chk("R1 credit pulse link down", int'(upd_req), 4);
    link_state = 2'd0;

    // R6: hold and coincident ack/credit
    cyc(300);
    chk("R6 requests held", int'(upd_req), 7);
    upd_ack = 3'b101; credit_free = 3'b100; cyc(1);
    upd_ack = '0; credit_free = '0;
    chk("R6 ack vs credit pulse", int'(upd_req), 6);

    // R8: disable
    type_en = 3'b110; cyc(1);
    chk("R8 disable clears", int'(upd_req[0]), 0);
    pulse_cf(3'b001); cyc(100);
    chk("R8 disabled stays quiet", int'(upd_req[0]), 0);
    type_en = '1;

    // R10: independent deadlines
    pulse_ack(3'b001); cyc(9);
    pulse_ack(3'b010); cyc(20);
    chk("R10 class0 due", int'(upd_req[0]), 1);
    chk("R10 class1 not yet", int'(upd_req[1]), 0);
    cyc(10);
    chk("R10 class1 due", int'(upd_req[1]), 1);

    finish_run();
  end

endmodule